// File: doc/BRIEF.md
# Clock control register bank

This block is the software-visible word store of a chip clock and reset controller. A host reaches it through a plain word bus. The bus has a word address (the byte offset divided by four), a write strobe with write data, and a read strobe whose data appears on a registered output one cycle later. The bank holds several groups of words: clock gating, source selection, divider settings, four PLL control words, peripheral reset controls and watchdog reset-routing controls. Every word takes a fixed value on cold reset.

Most words simply store what is written. The four PLL control words are rewritten by hardware on each write. Asserting power-down drops the lock indication and raises a sticky loss-of-lock flag. In normal mode the lock indication is always forced on, and the flag clears only when software writes a one to it. The software-reset word is write-only and reads as zero. Two offsets expose free-running counters kept outside this block: a seconds count and a 25 MHz tick count. Reads of those offsets pass the external values through, and writes to them are dropped. Word indices past the last implemented word read as zero and ignore writes.

Top module: `clkctl_regbank`

## Requirements
- R1: After cold reset the words read: index 0, 10, 12, 14, 15, 16 = 0xFFFFFFFF; 1 = 0x004AAAAA; 2 = 0x5413F855; 3 = 0x80222101; 4 = 0x80202101; 8 = 0x00001000; 9 = 0x80000000; 11 = 0xAA4F8F9F; 13 = 0x03000000; 17 = 0x00000003; 21 = 0x80C02105; 23 = 0x04000003; 24 = 0x81228606; 25 = 0x000000C8; all other implemented stored words 0.
- R2: A read strobe in one cycle places the addressed value on rd_data after the next rising clock edge, and rd_data holds its value in cycles without a read strobe.
- R3: A word index of 28 or more reads as zero, and a write there changes no implemented word.
- R4: A write to a PLL word (index 3, 4, 21 or 24) with bit 12 set stores the written value with bit 31 cleared and bit 30 set.
- R5: A write to a PLL word with bit 12 clear stores the written value with bit 31 set. Bit 30 becomes 0 if the written bit 30 is 1, and otherwise keeps its previous stored value.
- R6: Index 5 reads as zero at all times, including after any write to it.
- R7: A write to any other implemented index except 26 and 27 stores all 32 bits, and a later read returns them unchanged.
- R8: A read of index 26 returns sec_count_i and a read of index 27 returns tick_count_i, each as sampled at the read's clock edge. Writes to these two indices have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset, asynchronous assert |
| word_addr | input | 10 | Word index (byte offset / 4) within the 4 KiB window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, never asserted together with wr_en |
| rd_data | output | 32 | Registered read data |
| sec_count_i | input | 32 | External seconds counter value |
| tick_count_i | input | 32 | External 25 MHz tick counter value |

## Verification
The hardest state to reach from the ports is a set loss-of-lock flag that must survive later normal-mode writes carrying a zero in bit 30. The flag can only be raised by a power-down write, and it becomes visible only through a separate read. The stimulus therefore runs a power-down, a normal-mode write with bit 30 clear, and then a write-one-to-clear on a single PLL word, reading back after each step. Full sweeps over every index, including indices past the map, use two data patterns. Those patterns set bit 12 differently across the four PLL words, so both rewrite paths are exercised together with plain storage and aliasing of out-of-range writes.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int unsigned NUM_WORDS = 28;
    localparam int unsigned IDX_SWRST = 5;
    localparam int unsigned IDX_SEC   = 26;
    localparam int unsigned IDX_TICK  = 27;

    localparam int unsigned BIT_PDOWN = 12;
    localparam int unsigned BIT_LOSS  = 30;
    localparam int unsigned BIT_LOCK  = 31;

    typedef enum logic [2:0] {
        K_PLAIN,
        K_PLL,
        K_WO,
        K_SEC,
        K_TICK,
        K_NONE
    } kind_e;

    function automatic kind_e reg_kind(input int unsigned i);
        kind_e k;
        unique case (i)
            3, 4, 21, 24: k = K_PLL;
            IDX_SWRST:    k = K_WO;
            IDX_SEC:      k = K_SEC;
            IDX_TICK:     k = K_TICK;
            default:      k = (i < NUM_WORDS) ? K_PLAIN : K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [31:0] reg_reset(input int unsigned i);
        logic [31:0] v;
        unique case (i)
            0, 10, 12:  v = 32'hFFFF_FFFF;
            14, 15, 16: v = 32'hFFFF_FFFF;
            1:          v = 32'h004A_AAAA;
            2:          v = 32'h5413_F855;
            3:          v = 32'h8022_2101;
            4:          v = 32'h8020_2101;
            8:          v = 32'h0000_1000;
            9:          v = 32'h8000_0000;
            11:         v = 32'hAA4F_8F9F;
            13:         v = 32'h0300_0000;
            17:         v = 32'h0000_0003;
            21:         v = 32'h80C0_2105;
            23:         v = 32'h0400_0003;
            24:         v = 32'h8122_8606;
            25:         v = 32'h0000_00C8;
            default:    v = 32'h0000_0000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/clkctl_addr_dec.sv
module clkctl_addr_dec
    import clkctl_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned NR = NUM_WORDS,
    parameter int unsigned IW = $clog2(NR)
) (
    input  logic [AW-1:0] word_addr,
    output logic          in_range,
    output logic [IW-1:0] idx,
    output kind_e         kind
);

    always_comb begin
        in_range = (word_addr < AW'(NR));
        idx      = word_addr[IW-1:0];
        kind     = in_range ? reg_kind(int'(idx)) : K_NONE;
    end

endmodule

// File: rtl/clkctl_pll_wr.sv
module clkctl_pll_wr
    import clkctl_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] wr_word,
    input  logic          old_loss,
    output logic [DW-1:0] new_word
);

    always_comb begin
        new_word = wr_word;
        if (wr_word[BIT_PDOWN]) begin
            new_word[BIT_LOCK] = 1'b0;
            new_word[BIT_LOSS] = 1'b1;
        end else begin
            new_word[BIT_LOCK] = 1'b1;
            new_word[BIT_LOSS] = wr_word[BIT_LOSS] ? 1'b0 : old_loss;
        end
    end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 10,
    parameter int unsigned NR = NUM_WORDS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] word_addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic [DW-1:0] sec_count_i,
    input  logic [DW-1:0] tick_count_i
);

    localparam int unsigned IW = $clog2(NR);

    logic          in_range;
    logic [IW-1:0] idx;
    kind_e         kind;
    logic [DW-1:0] word_q [NR];
    logic [DW-1:0] rd_next;

    clkctl_addr_dec #(.AW(AW), .NR(NR), .IW(IW)) u_dec (
        .word_addr (word_addr),
        .in_range  (in_range),
        .idx       (idx),
        .kind      (kind)
    );

    for (genvar g = 0; g < NR; g++) begin : g_word
        localparam kind_e       KIND = reg_kind(g);
        localparam logic [DW-1:0] RST = DW'(reg_reset(g));
        logic hit;
        assign hit = wr_en && in_range && (idx == IW'(g));

        if (KIND == K_PLL) begin : g_pll
            logic [DW-1:0] upd;
            clkctl_pll_wr #(.DW(DW)) u_pll (
                .wr_word  (wr_data),
                .old_loss (word_q[g][BIT_LOSS]),
                .new_word (upd)
            );
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   word_q[g] <= RST;
                else if (hit) word_q[g] <= upd;
            end
        end else if (KIND == K_PLAIN) begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   word_q[g] <= RST;
                else if (hit) word_q[g] <= wr_data;
            end
        end else begin : g_nostore
            assign word_q[g] = '0;
        end
    end

    always_comb begin
        unique case (kind)
            K_NONE:  rd_next = '0;
            K_SEC:   rd_next = sec_count_i;
            K_TICK:  rd_next = tick_count_i;
            default: rd_next = word_q[idx];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 10,
    parameter int unsigned NR = 28
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] word_addr,
    input logic          wr_en,
    input logic          wr_pd,
    input logic          wr_loss,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] tick_count_i,
    input logic          pll0_lock,
    input logic          pll0_loss
);

    // R2: output holds between reads
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R3: beyond the map reads zero
    a_r3_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (word_addr >= AW'(NR))) |=> (rd_data == '0));

    // R4: power-down write on first PLL word
    a_r4_pdown_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (word_addr == AW'(3)) && wr_pd) |=> (!pll0_lock && pll0_loss));

    // R5: normal-mode write forces lock
    a_r5_lock_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (word_addr == AW'(3)) && !wr_pd) |=> pll0_lock);

    // R5: flag kept when not written one
    a_r5_loss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (word_addr == AW'(3)) && !wr_pd && !wr_loss) |=> $stable(pll0_loss));

    // R6: write-only word reads zero
    a_r6_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (word_addr == AW'(5))) |=> (rd_data == '0));

    // R8: tick counter passthrough
    a_r8_tick_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (word_addr == AW'(27))) |=> (rd_data == $past(tick_count_i)));

    // R2: one access per cycle
    a_r2_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

endmodule

bind clkctl_regbank clkctl_regbank_chk #(.DW(DW), .AW(AW), .NR(NR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_addr    (word_addr),
    .wr_en        (wr_en),
    .wr_pd        (wr_data[12]),
    .wr_loss      (wr_data[30]),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .tick_count_i (tick_count_i),
    .pll0_lock    (word_q[3][31]),
    .pll0_loss    (word_q[3][30])
);

// File: tb/clkctl_regbank_bench.sv
module clkctl_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NRW = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  word_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] sec_count_i = 32'h0000_0042;
    logic [31:0] tick_count_i = 32'h0123_4560;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] model [NRW];

    always #(CLK_PERIOD/2) clk = ~clk;

    clkctl_regbank u_clkctl_regbank (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_addr    (word_addr),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .sec_count_i  (sec_count_i),
        .tick_count_i (tick_count_i)
    );

    function automatic logic [31:0] cold_val(input int i);
        case (i)
            0, 10, 12, 14, 15, 16: return 32'hFFFF_FFFF;
            1:  return 32'h004A_AAAA;
            2:  return 32'h5413_F855;
            3:  return 32'h8022_2101;
            4:  return 32'h8020_2101;
            8:  return 32'h0000_1000;
            9:  return 32'h8000_0000;
            11: return 32'hAA4F_8F9F;
            13: return 32'h0300_0000;
            17: return 32'h0000_0003;
            21: return 32'h80C0_2105;
            23: return 32'h0400_0003;
            24: return 32'h8122_8606;
            25: return 32'h0000_00C8;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit is_pll(input int i);
        return (i == 3) || (i == 4) || (i == 21) || (i == 24);
    endfunction

    function automatic logic [31:0] expect_rd(input int i);
        if (i >= NRW) return 32'h0;
        if (i == 26)  return sec_count_i;
        if (i == 27)  return tick_count_i;
        return model[i];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input int i, input logic [31:0] d);
        @(negedge clk);
        word_addr = 10'(i);
        wr_data   = d;
        wr_en     = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (i < NRW && i != 5 && i != 26 && i != 27) begin
            if (is_pll(i)) begin
                logic [31:0] v;
                v = d;
                if (d[12]) begin
                    v[31] = 1'b0; v[30] = 1'b1;
                end else begin
                    v[31] = 1'b1;
                    v[30] = d[30] ? 1'b0 : model[i][30];
                end
                model[i] = v;
            end else begin
                model[i] = d;
            end
        end
    endtask

    task automatic rd(input int i, input string req);
        logic [31:0] exp;
        @(negedge clk);
        word_addr = 10'(i);
        rd_en     = 1'b1;
        exp       = expect_rd(i);
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp);
    endtask

    initial begin
        for (int i = 0; i < NRW; i++) model[i] = cold_val(i);
        repeat (3) @(negedge clk);
        check("R1 reset rd_data", rd_data, 32'h0);
        rst_n = 1'b1;

        // R1 R3 R6 R8: every index straight after reset
        for (int i = 0; i < 32; i++) rd(i, "R1 reset sweep");

        // R4 R5 R7 R3: first pattern over all indices
        for (int i = 0; i < 32; i++) wr(i, 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101));
        sec_count_i  = 32'h0000_0777;
        tick_count_i = 32'h0098_7650;
        for (int i = 0; i < 32; i++) rd(i, "R7 pattern A");

        // second pattern, complemented
        for (int i = 0; i < 32; i++) wr(i, ~(32'h1357_9BDF ^ (32'(i) * 32'h0101_0101)));
        for (int i = 0; i < 32; i++) rd(i, "R7 pattern B");

        // R5 sticky loss flag on PLL word 4
        wr(4, 32'h0000_1000); rd(4, "R4 pdown");
        check("R4 loss set", rd_data[30], 1'b1);
        check("R4 lock clr", rd_data[31], 1'b0);
        wr(4, 32'h0000_0055); rd(4, "R5 keep loss");
        check("R5 loss kept", rd_data[30], 1'b1);
        check("R5 lock set", rd_data[31], 1'b1);
        wr(4, 32'h4000_0055); rd(4, "R5 clear loss");
        check("R5 loss cleared", rd_data[30], 1'b0);
        wr(4, 32'h0000_0066); rd(4, "R5 stays clear");

        // R3: out of range writes alias nothing
        wr(40, 32'hDEAD_BEEF); rd(8, "R3 no alias 8");
        wr(1023, 32'hCAFE_F00D); rd(27, "R3 no alias 27"); rd(1023, "R3 oor read");

        // R6: write-only word after a write
        wr(5, 32'hFFFF_FFFF); rd(5, "R6 wo zero");

        // R8: counter writes ignored, read follows inputs
        wr(26, 32'h1111_1111); wr(27, 32'h2222_2222);
        sec_count_i = 32'h0000_1234; rd(26, "R8 sec");
        tick_count_i = 32'h00AB_CDE0; rd(27, "R8 tick");

        // R2: hold without read strobe
        tick_count_i = 32'h0000_0010;
        word_addr = 10'd1;
        repeat (3) @(negedge clk);
        check("R2 hold", rd_data, 32'h00AB_CDE0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule